// File: doc/BRIEF.md
# Variable-Length Integer Stream Decoder

This block turns a byte stream into integers. Each integer arrives as one to four bytes. The low seven bits of each byte carry one group of the value, and the top bit says whether more bytes follow. The first byte of an integer holds its most significant group. The decoder adds each group to an accumulator and shifts the accumulator left by seven before the next byte. It reports the finished integer together with the number of bytes it took.

Bytes enter on a valid/ready stream, and the decoder accepts one byte on every clock. The result is presented in the same cycle as the byte that ends the integer. Upstream ready is pulled low only while such a result waits on downstream backpressure.

An integer that runs past four bytes raises a one-cycle error. The decoder then throws the rest of that integer away and starts a fresh integer at the next byte. Both state registers clear after every result and after every error, so integers may follow each other with no gap.

Top module: `vlq_stream_decoder`

## Requirements
- R1: Bit 7 of each input byte is the continuation flag: 1 means more bytes follow and 0 ends the integer. Bits 6:0 are the only data bits, so the flag never appears in `out_value`.
- R2: Groups are assembled most significant first: the value is `(previous << 7) | byte[6:0]`. For example, the bytes 0x81 then 0x00 give 0x80.
- R3: A lone byte below 0x80 is a complete integer. For example, 0x3C gives 60 with `out_len` = 1.
- R4: `out_valid` is high in exactly the cycle the terminating byte is presented and not inside a discard. In that cycle `out_len` equals the number of bytes of the integer, from 1 to 4.
- R5: `in_ready` is low only when `out_valid` is high and `out_ready` is low. A stalled terminating byte is not consumed, and its result is shown again until it is accepted.
- R6: Leading 0x80 bytes (zero groups with the flag set) are legal and leave the value unchanged, but they count toward `out_len` and toward the 4-byte limit.
- R7: When 4 bytes with the flag set have been taken, the next byte raises `out_err` for one cycle and gives no `out_valid`. If that byte has its flag set, every byte up to and including the next byte with the flag clear is dropped with no output and no error.
- R8: After a result or an error the decoder starts from an empty accumulator. A new integer may begin on the very next byte with no idle cycle.
- R9: After reset, with no input, `out_valid` = 0, `out_err` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte: bit 7 is the continuation flag, bits 6:0 are data |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_valid | output | 1 | Completed integer present |
| out_ready | input | 1 | Downstream takes the result |
| out_value | output | 28 | Decoded integer, meaningful while out_valid is high |
| out_len | output | 3 | Byte count of the integer, meaningful while out_valid is high |
| out_err | output | 1 | One-cycle pulse: the integer is longer than 4 bytes |

## Verification
The assertions check these properties on every cycle:
- A result never appears for a byte whose flag is set.
- Ready falls only when a result is stalled.
- An error and a result never appear together.
- The byte count stays within its range.
- The state is empty after each result and after each error.
- A discard ends at a byte whose flag is clear.

Some behaviour only the bench scenarios can show:
- the exact values built from the grouped bytes;
- the effect of leading zero groups;
- that the bytes dropped after an overflow produce nothing;
- that results are repeated while the stream is stalled.

These are shown by comparing the outputs against a model driven with random byte streams and with random backpressure.

// File: rtl/vlq_dec_pkg.sv
package vlq_dec_pkg;

    // Collect: building an integer. Discard: dropping an over-long integer.
    typedef enum logic [0:0] {
        MODE_COLLECT = 1'b0,
        MODE_DISCARD = 1'b1
    } vlq_mode_e;

endpackage

// File: rtl/vlq_byte_split.sv
module vlq_byte_split #(
    parameter int GRP_W = 7
) (
    input  logic [GRP_W:0]   byte_i,
    output logic             cont_o,
    output logic [GRP_W-1:0] grp_o
);

    always_comb begin
        cont_o = byte_i[GRP_W];
        grp_o  = byte_i[GRP_W-1:0];
    end

endmodule

// File: rtl/vlq_accum.sv
module vlq_accum
    import vlq_dec_pkg::*;
#(
    parameter int GRP_W    = 7,
    parameter int MAX_GRPS = 4,
    localparam int VAL_W   = GRP_W * MAX_GRPS,
    localparam int CNT_W   = $clog2(MAX_GRPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             cont_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic [VAL_W-1:0] acc_o,
    output logic [CNT_W-1:0] cnt_o,
    output vlq_mode_e        mode_o
);

    typedef struct packed {
        logic [VAL_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        vlq_mode_e        mode;
    } acc_state_t;

    localparam acc_state_t RST_STATE = '{acc: '0, cnt: '0, mode: MODE_COLLECT};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_GRPS);

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            if (st_q.mode == MODE_DISCARD) begin
                // Drop the byte; leave the discard at the last byte.
                if (!cont_i) begin
                    st_d.mode = MODE_COLLECT;
                end
            end else if (st_q.cnt == CNT_FULL) begin
                // Over-long integer: clear and drop what remains of it.
                st_d.acc  = '0;
                st_d.cnt  = '0;
                st_d.mode = cont_i ? MODE_DISCARD : MODE_COLLECT;
            end else if (cont_i) begin
                st_d.acc = {st_q.acc[VAL_W-GRP_W-1:0], grp_i};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                // Terminating byte: its result is sent out this cycle.
                st_d.acc = '0;
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign cnt_o  = st_q.cnt;
    assign mode_o = st_q.mode;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL) else $error("count past limit"); // R7

    AST_CLEAR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !cont_i && st_q.mode == MODE_COLLECT)
        |=> (st_q.cnt == '0 && st_q.acc == '0 && st_q.mode == MODE_COLLECT))
        else $error("state not cleared after result"); // R8

    AST_CLEAR_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && st_q.mode == MODE_COLLECT && st_q.cnt == CNT_FULL)
        |=> (st_q.cnt == '0 && st_q.acc == '0))
        else $error("state not cleared after overflow"); // R8

    AST_DISCARD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !cont_i && st_q.mode == MODE_DISCARD)
        |=> (st_q.mode == MODE_COLLECT))
        else $error("discard did not end"); // R7

endmodule

// File: rtl/vlq_emit.sv
module vlq_emit
    import vlq_dec_pkg::*;
#(
    parameter int GRP_W    = 7,
    parameter int MAX_GRPS = 4,
    localparam int VAL_W   = GRP_W * MAX_GRPS,
    localparam int CNT_W   = $clog2(MAX_GRPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             cont_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [VAL_W-1:0] acc_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  vlq_mode_e        mode_i,
    input  logic             out_ready_i,
    output logic             in_ready_o,
    output logic             take_o,
    output logic             out_valid_o,
    output logic [VAL_W-1:0] out_value_o,
    output logic [CNT_W-1:0] out_len_o,
    output logic             out_err_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_GRPS);

    logic collecting;
    logic full;

    always_comb begin
        collecting  = (mode_i == MODE_COLLECT);
        full        = (cnt_i == CNT_FULL);
        out_valid_o = in_valid_i && collecting && !full && !cont_i;
        out_err_o   = in_valid_i && collecting && full;
        out_value_o = {acc_i[VAL_W-GRP_W-1:0], grp_i};
        out_len_o   = cnt_i + CNT_W'(1);
        in_ready_o  = !out_valid_o || out_ready_i;
        take_o      = in_valid_i && in_ready_o;
    end

    AST_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready_o |-> (out_valid_o && !out_ready_i))
        else $error("ready low without stall"); // R5

    AST_VALID_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (in_valid_i && !cont_i))
        else $error("result on continuing byte"); // R1

    AST_NO_VALID_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid_o && out_err_o))
        else $error("result and error together"); // R7

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_len_o >= CNT_W'(1) && out_len_o <= CNT_FULL))
        else $error("length out of range"); // R4

endmodule

// File: rtl/vlq_stream_decoder.sv
module vlq_stream_decoder
    import vlq_dec_pkg::*;
#(
    parameter int GRP_W    = 7,
    parameter int MAX_GRPS = 4,
    localparam int BYTE_W  = GRP_W + 1,
    localparam int VAL_W   = GRP_W * MAX_GRPS,
    localparam int CNT_W   = $clog2(MAX_GRPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VAL_W-1:0]  out_value,
    output logic [CNT_W-1:0]  out_len,
    output logic              out_err
);

    localparam logic [VAL_W-1:0] ONE_GRP_LIM = VAL_W'(1) << GRP_W;

    logic             cont;
    logic [GRP_W-1:0] grp;
    logic [VAL_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    vlq_mode_e        mode;
    logic             take;

    vlq_byte_split #(.GRP_W(GRP_W)) split_i (
        .byte_i (in_byte),
        .cont_o (cont),
        .grp_o  (grp)
    );

    vlq_accum #(.GRP_W(GRP_W), .MAX_GRPS(MAX_GRPS)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .cont_i (cont),
        .grp_i  (grp),
        .acc_o  (acc),
        .cnt_o  (cnt),
        .mode_o (mode)
    );

    vlq_emit #(.GRP_W(GRP_W), .MAX_GRPS(MAX_GRPS)) emit_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .cont_i      (cont),
        .grp_i       (grp),
        .acc_i       (acc),
        .cnt_i       (cnt),
        .mode_i      (mode),
        .out_ready_i (out_ready),
        .in_ready_o  (in_ready),
        .take_o      (take),
        .out_valid_o (out_valid),
        .out_value_o (out_value),
        .out_len_o   (out_len),
        .out_err_o   (out_err)
    );

    AST_SINGLE_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == CNT_W'(1)) |-> (out_value < ONE_GRP_LIM))
        else $error("one-byte result too large"); // R3

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err && in_valid) |=> !out_err)
        else $error("error held over two cycles"); // R7

endmodule

// File: tb/vlq_stream_decoder_tb_top.sv
module vlq_stream_decoder_tb_top;

    localparam int VAL_W = 28;
    localparam int LEN_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [VAL_W-1:0] out_value;
    logic [LEN_W-1:0] out_len;
    logic             out_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    int               m_cnt  = 0;
    logic [VAL_W-1:0] m_acc  = '0;
    bit               m_skip = 1'b0;

    always #10 clk = ~clk;

    vlq_stream_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_value (out_value),
        .out_len   (out_len),
        .out_err   (out_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one byte for one cycle, check the outputs, then advance the model.
    task automatic send(input logic [7:0] b, input bit vld, input bit rdy, input string req);
        bit               e_valid, e_err, e_ready;
        logic [VAL_W-1:0] e_val;
        int               e_len;
        @(negedge clk);
        in_byte   = b;
        in_valid  = vld;
        out_ready = rdy;
        #2;
        e_valid = 1'b0;
        e_err   = 1'b0;
        e_val   = {m_acc[VAL_W-8:0], b[6:0]};
        e_len   = m_cnt + 1;
        if (vld && !m_skip) begin
            if (m_cnt == 4) e_err = 1'b1;
            else if (!b[7]) e_valid = 1'b1;
        end
        e_ready = !e_valid || rdy;
        chk("R5", "in_ready", 32'(in_ready), 32'(e_ready));
        chk("R4", "out_valid", 32'(out_valid), 32'(e_valid));
        chk("R7", "out_err", 32'(out_err), 32'(e_err));
        if (e_valid) begin
            chk(req, "out_value", 32'(out_value), 32'(e_val));
            chk("R4", "out_len", 32'(out_len), 32'(e_len));
        end
        if (vld && e_ready) begin
            if (m_skip) begin
                if (!b[7]) m_skip = 1'b0;
            end else if (m_cnt == 4) begin
                m_cnt = 0; m_acc = '0; m_skip = b[7];
            end else if (b[7]) begin
                m_acc = {m_acc[VAL_W-8:0], b[6:0]}; m_cnt++;
            end else begin
                m_cnt = 0; m_acc = '0;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9: idle outputs after reset
        chk("R9", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R9", "reset out_err", 32'(out_err), 32'd0);
        chk("R9", "reset in_ready", 32'(in_ready), 32'd1);

        // R3: single byte 60
        send(8'h3C, 1, 1, "R3");
        // R2: 0x81 0x00 -> 0x80, directly after the previous result (R8)
        send(8'h81, 1, 1, "R2");
        send(8'h00, 1, 1, "R2");
        // R1: flag bits are stripped: 0xFF 0x7F -> 0x3FFF
        send(8'hFF, 1, 1, "R1");
        send(8'h7F, 1, 1, "R1");
        // R6: leading zero groups 0x80 0x80 0x05 -> 5, length 3
        send(8'h80, 1, 1, "R6");
        send(8'h80, 1, 1, "R6");
        send(8'h05, 1, 1, "R6");
        // R4: longest legal integer, 4 bytes -> 0xFFFFFFF
        send(8'hFF, 1, 1, "R4");
        send(8'hFF, 1, 1, "R4");
        send(8'hFF, 1, 1, "R4");
        send(8'h7F, 1, 1, "R4");
        // R7: fifth byte with flag set, then dropped bytes up to a clear flag
        for (int i = 0; i < 4; i++) send(8'h81, 1, 1, "R7");
        send(8'h81, 1, 1, "R7");
        send(8'h90, 1, 1, "R7");
        send(8'h05, 1, 1, "R7");
        // R8: fresh integer right after the discard
        send(8'h03, 1, 1, "R8");
        // R7: fifth byte with flag clear ends the bad integer; R8 restart
        for (int i = 0; i < 4; i++) send(8'h80, 1, 1, "R7");
        send(8'h01, 1, 1, "R7");
        send(8'h82, 1, 1, "R8");
        send(8'h01, 1, 1, "R8");
        // R5: stalled terminating byte is held and repeated
        send(8'h85, 1, 1, "R5");
        send(8'h11, 1, 0, "R5");
        send(8'h11, 1, 0, "R5");
        send(8'h11, 1, 1, "R5");
        // R5: a continuing byte is taken even with out_ready low
        send(8'h83, 1, 0, "R5");
        send(8'h22, 1, 1, "R5");

        // Random streams with gaps and backpressure
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (($urandom % 10) < 4) b[7] = 1'b0; else b[7] = 1'b1;
            send(b, ($urandom % 8) != 0, ($urandom % 4) != 0, "R2");
        end
        send(8'h00, 0, 1, "R9");
        finish_run();
    end

endmodule